// File: doc/BRIEF.md
# Egress VLAN Tag Editor

This block sits on the byte stream leaving a switch port and edits each frame as it passes through. A frame arrives one byte per accepted cycle. Start and end markers frame it, and its last four bytes are a frame check sequence. Per frame, the block can add an 802.1Q tag to an untagged frame, built from the ingress port's default VLAN identifier and priority. It can delete the tag from a tagged frame. It can also limit a kept tag's priority so that it does not exceed the default priority. The incoming check sequence is always discarded and a new CRC-32 is appended. Short results are zero-padded to the minimum payload length.

Each frame's output length is the same as its input length, 4 bytes longer, or 4 bytes shorter, plus any padding. To make room for the extra bytes, the block lowers its ready output while it emits a tag, padding or the check sequence. The sender holds the current byte until ready returns. Four input bytes are held in a short delay line, so that the incoming check sequence can be recognised and dropped when the end marker arrives.

Top module: `vtag_egress_editor`

## Requirements
- R1: After reset, out_valid is low and in_ready is high.
- R2: With insertion enabled, a frame is untagged unless input bytes 12 and 13 are 0x81 then 0x00. An untagged frame gets four bytes inserted after its byte 11: 0x81, 0x00, {prio[2:0], 0, pvid[11:8]}, pvid[7:0].
- R3: A frame already tagged (bytes 12–13 = 0x81, 0x00) is never given a second tag.
- R4: With removal enabled, a tagged frame leaves without its bytes 12 to 15.
- R5: With removal enabled, an untagged frame leaves with its payload unchanged.
- R6: With both insertion and removal enabled, tagged frames are stripped and untagged frames are tagged.
- R7: With the ceiling enabled, a kept tag whose priority (bits 7:5 of byte 14) is above prio has those bits replaced by prio. Otherwise the tag's priority is left as it is.
- R8: The last four input bytes of a frame are dropped. After the last payload byte, the block appends the CRC-32 of the output payload: reflected, polynomial 0x04C11DB7, initial value all ones, inverted, least significant byte first.
- R9: An output payload shorter than 60 bytes is padded with zero bytes to exactly 60 before the check sequence.
- R10: The configuration inputs are sampled with the start byte of a frame. Changes later in the frame do not affect it.
- R11: in_ready is low while a tag, padding or check-sequence byte is being produced. A held input byte is neither lost nor duplicated, so frames may be sent back to back.
- R12: out_sof marks the first output byte and out_eof the last check-sequence byte of each frame. Input frames are at least 20 bytes long, including the check sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte present |
| in_sof | input | 1 | Input byte is the first of a frame |
| in_eof | input | 1 | Input byte is the last of a frame (last check-sequence byte) |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block accepts the input byte this cycle |
| cfg_ins_en | input | 1 | Tag insertion enable |
| cfg_rem_en | input | 1 | Tag removal enable |
| cfg_ceil_en | input | 1 | Priority ceiling enable |
| cfg_prio | input | 3 | Default tag priority |
| cfg_pvid | input | 12 | Default VLAN identifier |
| out_valid | output | 1 | Output byte present |
| out_sof | output | 1 | First byte of an output frame |
| out_eof | output | 1 | Last byte of an output frame |
| out_data | output | 8 | Output byte |

## Verification
The bench builds the block with its default parameters: tag offset 12, minimum payload 60 and tag identifier 0x8100. With these values, payloads of 16 to 70 bytes cover both sides of the padding boundary. They include a tagged 64-byte payload that is stripped to exactly 60 bytes and a 16-byte payload where the tag decision and insertion come just before the end marker. Back-to-back frames with no idle cycle exercise the hold on in_ready, and a near-miss identifier (0x81 0x01) exercises the tag test.

// File: rtl/vtag_pkg.sv
package vtag_pkg;

  typedef enum logic [1:0] {
    ST_PASS = 2'd0,
    ST_TAG  = 2'd1,
    ST_PAD  = 2'd2,
    ST_FCS  = 2'd3
  } edit_st_e;

  typedef struct packed {
    logic        ins_en;
    logic        rem_en;
    logic        ceil_en;
    logic [2:0]  prio;
    logic [11:0] pvid;
  } edit_cfg_t;

  localparam int          FCS_BYTES     = 4;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  // one byte of reflected CRC-32, LSB first
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int b = 0; b < 8; b++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/vtag_fcs_delay.sv
module vtag_fcs_delay
  import vtag_pkg::*;
#(
  parameter int DEPTH = FCS_BYTES
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic       restart,
  input  logic [7:0] din,
  output logic       pop_vld,
  output logic [7:0] pop_data,
  output logic [7:0] newest
);

  localparam int              CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [7:0]       slot_q [DEPTH];
  logic [CNT_W-1:0] fill_q, fill_d;

  always_comb begin
    fill_d = fill_q;
    if (push) begin
      if (restart)            fill_d = CNT_W'(1);
      else if (fill_q != FULL) fill_d = fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_q <= '0;
    else if (push) fill_q <= fill_d;
  end

  always_ff @(posedge clk) begin
    if (push) begin
      slot_q[0] <= din;
      for (int i = 1; i < DEPTH; i++) slot_q[i] <= slot_q[i-1];
    end
  end

  assign pop_vld  = push & ~restart & (fill_q == FULL);
  assign pop_data = slot_q[DEPTH-1];
  assign newest   = slot_q[0];

endmodule

// File: rtl/vtag_crc_gen.sv
module vtag_crc_gen
  import vtag_pkg::*;
(
  input  logic        clk,
  input  logic        upd,
  input  logic        first,
  input  logic [7:0]  din,
  output logic [31:0] fcs
);

  logic [31:0] crc_q, crc_d;

  always_comb crc_d = crc32_step(first ? 32'hFFFF_FFFF : crc_q, din);

  always_ff @(posedge clk) begin
    if (upd) crc_q <= crc_d;
  end

  assign fcs = ~crc_q;

endmodule

// File: rtl/vtag_edit_ctrl.sv
module vtag_edit_ctrl
  import vtag_pkg::*;
#(
  parameter int          TAG_OFS = 12,
  parameter int          MIN_PAY = 60,
  parameter logic [15:0] TPID    = 16'h8100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic [7:0]  in_data,
  input  edit_cfg_t   cfg_in,
  input  logic        pop_vld,
  input  logic [7:0]  pop_data,
  input  logic [7:0]  newest,
  input  logic [31:0] fcs,
  output logic        in_ready,
  output logic        acc,
  output logic        restart,
  output logic        emit_v,
  output logic [7:0]  emit_byte,
  output logic        emit_first,
  output logic        emit_last,
  output logic        crc_upd
);

  localparam int IDX_W = $clog2(TAG_OFS + 2*FCS_BYTES + 1);
  localparam int PAY_W = $clog2(MIN_PAY + 1);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;
  localparam logic [IDX_W-1:0] K_INS   = IDX_W'(TAG_OFS - 1);
  localparam logic [IDX_W-1:0] K_TP    = IDX_W'(TAG_OFS);
  localparam logic [IDX_W-1:0] K_TP2   = IDX_W'(TAG_OFS + 1);
  localparam logic [IDX_W-1:0] K_TCI   = IDX_W'(TAG_OFS + 2);
  localparam logic [IDX_W-1:0] K_END   = IDX_W'(TAG_OFS + 3);
  localparam logic [IDX_W-1:0] K_LAG   = IDX_W'(FCS_BYTES);
  localparam logic [PAY_W-1:0] PAY_MIN = PAY_W'(MIN_PAY);

  edit_st_e         state_q, state_d;
  logic [1:0]       sub_q, sub_d;
  logic [IDX_W-1:0] idx_q, idx_d, cur_idx, pop_idx;
  logic             tagged_q, tagged_d;
  edit_cfg_t        cfg_q, cfg_d;
  logic [PAY_W-1:0] pay_q, pay_d;
  logic             do_ins, do_rem, in_tag_span, clamp_hit;

  assign in_ready    = (state_q == ST_PASS);
  assign acc         = in_valid & in_ready;
  assign restart     = acc & in_sof;
  assign cur_idx     = in_sof ? '0 : idx_q;
  assign pop_idx     = cur_idx - K_LAG;
  assign do_ins      = cfg_q.ins_en & ~tagged_q;
  assign do_rem      = cfg_q.rem_en & tagged_q;
  assign in_tag_span = (pop_idx >= K_TP) && (pop_idx <= K_END);
  assign clamp_hit   = (pop_idx == K_TCI) && tagged_q && !do_rem && cfg_q.ceil_en &&
                       (pop_data[7:5] > cfg_q.prio);

  // byte selection
  always_comb begin
    emit_v     = 1'b0;
    emit_byte  = pop_data;
    emit_first = 1'b0;
    emit_last  = 1'b0;
    unique case (state_q)
      ST_PASS: begin
        if (pop_vld && !(do_rem && in_tag_span)) begin
          emit_v     = 1'b1;
          emit_first = (pop_idx == '0);
          if (clamp_hit) emit_byte = {cfg_q.prio, pop_data[4:0]};
        end
      end
      ST_TAG: begin
        emit_v = 1'b1;
        unique case (sub_q)
          2'd0:    emit_byte = TPID[15:8];
          2'd1:    emit_byte = TPID[7:0];
          2'd2:    emit_byte = {cfg_q.prio, 1'b0, cfg_q.pvid[11:8]};
          default: emit_byte = cfg_q.pvid[7:0];
        endcase
      end
      ST_PAD: begin
        emit_v    = 1'b1;
        emit_byte = 8'h00;
      end
      default: begin
        emit_v    = 1'b1;
        emit_byte = fcs[{sub_q, 3'b000} +: 8];
        emit_last = (sub_q == 2'd3);
      end
    endcase
  end

  assign crc_upd = emit_v & (state_q != ST_FCS);

  // payload length tracking
  always_comb begin
    pay_d = pay_q;
    if (crc_upd) begin
      if (emit_first)            pay_d = PAY_W'(1);
      else if (pay_q != PAY_MIN) pay_d = pay_q + 1'b1;
    end
  end

  // next state
  always_comb begin
    state_d  = state_q;
    sub_d    = sub_q;
    idx_d    = idx_q;
    tagged_d = tagged_q;
    cfg_d    = cfg_q;
    if (acc) begin
      idx_d = (cur_idx == IDX_MAX) ? IDX_MAX : cur_idx + 1'b1;
      if (in_sof) begin
        cfg_d    = cfg_in;
        tagged_d = 1'b0;
      end
      if (cur_idx == K_TP2) tagged_d = (newest == TPID[15:8]) && (in_data == TPID[7:0]);
    end
    unique case (state_q)
      ST_PASS: begin
        if (pop_vld && (pop_idx == K_INS) && do_ins) begin
          state_d = ST_TAG;
          sub_d   = 2'd0;
        end
        if (acc && in_eof) begin
          state_d = (pay_d >= PAY_MIN) ? ST_FCS : ST_PAD;
          sub_d   = 2'd0;
        end
      end
      ST_TAG: begin
        sub_d = sub_q + 2'd1;
        if (sub_q == 2'd3) state_d = ST_PASS;
      end
      ST_PAD: begin
        if (pay_d >= PAY_MIN) begin
          state_d = ST_FCS;
          sub_d   = 2'd0;
        end
      end
      default: begin
        sub_d = sub_q + 2'd1;
        if (sub_q == 2'd3) state_d = ST_PASS;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_PASS;
      sub_q    <= '0;
      idx_q    <= '0;
      tagged_q <= 1'b0;
      cfg_q    <= '0;
      pay_q    <= '0;
    end else begin
      state_q <= state_d;
      sub_q   <= sub_d;
      pay_q   <= pay_d;
      if (acc) begin
        idx_q    <= idx_d;
        tagged_q <= tagged_d;
        cfg_q    <= cfg_d;
      end
    end
  end

  AST_NO_DOUBLE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TAG) |-> !tagged_q) else $error("tag added to tagged frame"); // R3

  AST_STRIP_ONLY_TAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PASS && pop_vld && in_tag_span && !emit_v) |-> (tagged_q && cfg_q.rem_en))
    else $error("bytes dropped from a frame that is not being stripped"); // R4

  AST_PRIO_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_v && state_q == ST_PASS && pop_idx == K_TCI && tagged_q && cfg_q.ceil_en && !cfg_q.rem_en)
    |-> (emit_byte[7:5] <= cfg_q.prio)) else $error("priority above ceiling"); // R7

endmodule

// File: rtl/vtag_egress_editor.sv
module vtag_egress_editor
  import vtag_pkg::*;
#(
  parameter int          TAG_OFS = 12,
  parameter int          MIN_PAY = 60,
  parameter logic [15:0] TPID    = 16'h8100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  input  logic        cfg_ins_en,
  input  logic        cfg_rem_en,
  input  logic        cfg_ceil_en,
  input  logic [2:0]  cfg_prio,
  input  logic [11:0] cfg_pvid,
  output logic        out_valid,
  output logic        out_sof,
  output logic        out_eof,
  output logic [7:0]  out_data
);

  localparam int              OCNT_W  = 12;
  localparam logic [OCNT_W-1:0] OCNT_MAX = '1;
  localparam logic [OCNT_W-1:0] MIN_OUT  = OCNT_W'(MIN_PAY + FCS_BYTES - 1);

  logic        rst_meta_q, rst_s_q;
  edit_cfg_t   cfg_in;
  logic        acc, restart, pop_vld;
  logic [7:0]  pop_data, newest;
  logic [31:0] fcs;
  logic        emit_v, emit_first, emit_last, crc_upd;
  logic [7:0]  emit_byte;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s_q    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s_q    <= rst_meta_q;
    end
  end

  assign cfg_in = '{ins_en: cfg_ins_en, rem_en: cfg_rem_en, ceil_en: cfg_ceil_en,
                    prio: cfg_prio, pvid: cfg_pvid};

  vtag_fcs_delay #(.DEPTH(FCS_BYTES)) u_delay (
    .clk      (clk),
    .rst_n    (rst_s_q),
    .push     (acc),
    .restart  (restart),
    .din      (in_data),
    .pop_vld  (pop_vld),
    .pop_data (pop_data),
    .newest   (newest)
  );

  vtag_edit_ctrl #(.TAG_OFS(TAG_OFS), .MIN_PAY(MIN_PAY), .TPID(TPID)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_s_q),
    .in_valid   (in_valid),
    .in_sof     (in_sof),
    .in_eof     (in_eof),
    .in_data    (in_data),
    .cfg_in     (cfg_in),
    .pop_vld    (pop_vld),
    .pop_data   (pop_data),
    .newest     (newest),
    .fcs        (fcs),
    .in_ready   (in_ready),
    .acc        (acc),
    .restart    (restart),
    .emit_v     (emit_v),
    .emit_byte  (emit_byte),
    .emit_first (emit_first),
    .emit_last  (emit_last),
    .crc_upd    (crc_upd)
  );

  vtag_crc_gen u_crc (
    .clk   (clk),
    .upd   (crc_upd),
    .first (emit_first),
    .din   (emit_byte),
    .fcs   (fcs)
  );

  always_ff @(posedge clk or negedge rst_s_q) begin
    if (!rst_s_q) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
    end else begin
      out_valid <= emit_v;
      out_sof   <= emit_v & emit_first;
      out_eof   <= emit_v & emit_last;
    end
  end

  always_ff @(posedge clk) begin
    if (emit_v) out_data <= emit_byte;
  end

  // output framing monitor state
  logic              out_open_q;
  logic [OCNT_W-1:0] out_cnt_q;

  always_ff @(posedge clk or negedge rst_s_q) begin
    if (!rst_s_q) begin
      out_open_q <= 1'b0;
      out_cnt_q  <= '0;
    end else if (out_valid) begin
      out_open_q <= !out_eof;
      if (out_sof)                    out_cnt_q <= OCNT_W'(1);
      else if (out_cnt_q != OCNT_MAX) out_cnt_q <= out_cnt_q + 1'b1;
    end
  end

  AST_BUSY_EMITS: assert property (@(posedge clk) disable iff (!rst_s_q)
    !in_ready |=> out_valid) else $error("gap while input is held"); // R11

  AST_FRAME_ORDER: assert property (@(posedge clk) disable iff (!rst_s_q)
    out_sof |-> !out_open_q) else $error("frame start inside open frame"); // R12

  AST_MIN_LENGTH: assert property (@(posedge clk) disable iff (!rst_s_q)
    out_eof |-> (out_cnt_q >= MIN_OUT)) else $error("output frame below minimum"); // R9

endmodule

// File: tb/vtag_egress_editor_bench.sv
module vtag_egress_editor_bench;

  logic        clk;
  logic        rst_n;
  logic        in_valid, in_sof, in_eof, in_ready;
  logic [7:0]  in_data;
  logic        cfg_ins_en, cfg_rem_en, cfg_ceil_en;
  logic [2:0]  cfg_prio;
  logic [11:0] cfg_pvid;
  logic        out_valid, out_sof, out_eof;
  logic [7:0]  out_data;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  logic [9:0]  expq [$];
  string       labq [$];
  logic [7:0]  pl   [$];

  initial clk = 1'b0;
  always #5 clk = ~clk;

  vtag_egress_editor u_vtag_egress_editor (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_sof (in_sof), .in_eof (in_eof), .in_data (in_data),
    .in_ready (in_ready),
    .cfg_ins_en (cfg_ins_en), .cfg_rem_en (cfg_rem_en), .cfg_ceil_en (cfg_ceil_en),
    .cfg_prio (cfg_prio), .cfg_pvid (cfg_pvid),
    .out_valid (out_valid), .out_sof (out_sof), .out_eof (out_eof), .out_data (out_data)
  );

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int b = 0; b < 8; b++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R12", "unexpected output byte", {out_sof, out_eof, out_data}, 0);
      end else begin
        logic [9:0] e;
        string      l;
        e = expq.pop_front();
        l = labq.pop_front();
        check({out_sof, out_eof, out_data} == e, l, "output {sof,eof,data}",
              {out_sof, out_eof, out_data}, e);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      check(1'b0, "R11", "watchdog expired", cyc, 100000);
      summary();
      $finish;
    end
  end

  // build a payload (no check sequence) in pl
  task automatic mk(input int len, input bit tg, input logic [15:0] tci, input logic [7:0] seed);
    pl.delete();
    for (int i = 0; i < len; i++) pl.push_back(8'(i * 7) + seed);
    if (tg) begin
      pl[12] = 8'h81; pl[13] = 8'h00; pl[14] = tci[15:8]; pl[15] = tci[7:0];
    end else begin
      pl[12] = 8'h08; pl[13] = 8'h00;
    end
  endtask

  // compute the expected output from pl, then drive pl with its own check sequence
  task automatic send(input bit ins, input bit rem, input bit ceil, input logic [2:0] prio,
                      input logic [11:0] pvid, input string req, input bit wiggle, input bit gap);
    logic [7:0]  o  [$];
    logic [7:0]  fr [$];
    logic [31:0] c;
    bit          tg;
    tg = (pl.size() >= 14) && (pl[12] == 8'h81) && (pl[13] == 8'h00);
    if (rem && tg) begin
      for (int i = 0; i < pl.size(); i++) if (i < 12 || i > 15) o.push_back(pl[i]);
    end else if (ins && !tg) begin
      for (int i = 0; i < pl.size(); i++) begin
        if (i == 12) begin
          o.push_back(8'h81); o.push_back(8'h00);
          o.push_back({prio, 1'b0, pvid[11:8]}); o.push_back(pvid[7:0]);
        end
        o.push_back(pl[i]);
      end
    end else begin
      for (int i = 0; i < pl.size(); i++) o.push_back(pl[i]);
      if (tg && ceil && (o[14][7:5] > prio)) o[14][7:5] = prio;
    end
    while (o.size() < 60) o.push_back(8'h00);
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < o.size(); i++) c = crc_step(c, o[i]);
    c = ~c;
    for (int k = 0; k < 4; k++) o.push_back(c[8*k +: 8]);
    for (int i = 0; i < o.size(); i++) begin
      expq.push_back({i == 0, i == o.size() - 1, o[i]});
      labq.push_back(req);
    end

    c = 32'hFFFF_FFFF;
    for (int i = 0; i < pl.size(); i++) begin
      fr.push_back(pl[i]);
      c = crc_step(c, pl[i]);
    end
    c = ~c;
    for (int k = 0; k < 4; k++) fr.push_back(c[8*k +: 8]);

    for (int i = 0; i < fr.size(); i++) begin
      @(negedge clk);
      if (i == 0) begin
        cfg_ins_en = ins; cfg_rem_en = rem; cfg_ceil_en = ceil; cfg_prio = prio; cfg_pvid = pvid;
      end
      if (i == 1 && wiggle) begin
        cfg_ins_en = ~ins; cfg_rem_en = ~rem; cfg_ceil_en = ~ceil; cfg_prio = ~prio; cfg_pvid = ~pvid;
      end
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_eof   = (i == fr.size() - 1);
      in_data  = fr[i];
      while (!in_ready) @(negedge clk);
    end
    if (gap) begin
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h00;
    cfg_ins_en = 1'b0; cfg_rem_en = 1'b0; cfg_ceil_en = 1'b0; cfg_prio = 3'd0; cfg_pvid = 12'd0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    // R8: plain pass, check sequence regenerated
    mk(64, 1'b0, 16'h0, 8'h03); send(0, 0, 0, 3'd0, 12'h000, "R8", 0, 1);
    // R2: insertion into untagged frames, including a near-miss identifier
    mk(60, 1'b0, 16'h0, 8'h05); send(1, 0, 0, 3'd5, 12'hABC, "R2", 0, 1);
    mk(40, 1'b0, 16'h0, 8'h11); pl[12] = 8'h81; pl[13] = 8'h01;
    send(1, 0, 0, 3'd2, 12'h123, "R2", 0, 1);
    // R3: tagged frame keeps its single tag
    mk(64, 1'b1, 16'h6005, 8'h07); send(1, 0, 0, 3'd1, 12'h055, "R3", 0, 1);
    // R4 / R5: removal
    mk(70, 1'b1, 16'h2001, 8'h09); send(0, 1, 0, 3'd4, 12'h00F, "R4", 0, 1);
    mk(64, 1'b0, 16'h0, 8'h21);    send(0, 1, 0, 3'd4, 12'h00F, "R5", 0, 1);
    // R6: both enabled
    mk(64, 1'b1, 16'hA7FF, 8'h31); send(1, 1, 0, 3'd6, 12'h456, "R6", 0, 1);
    mk(64, 1'b0, 16'h0, 8'h41);    send(1, 1, 0, 3'd6, 12'h456, "R6", 0, 1);
    // R7: priority ceiling
    mk(64, 1'b1, 16'hE00A, 8'h51); send(0, 0, 1, 3'd3, 12'h777, "R7", 0, 1);
    mk(64, 1'b1, 16'h4ABC, 8'h52); send(0, 0, 1, 3'd3, 12'h777, "R7", 0, 1);
    mk(64, 1'b1, 16'hE00A, 8'h53); send(0, 0, 0, 3'd3, 12'h777, "R7", 0, 1);
    mk(64, 1'b1, 16'hC123, 8'h54); send(1, 0, 1, 3'd1, 12'h777, "R7", 0, 1);
    // R9: padding, and the exact-length boundary
    mk(20, 1'b0, 16'h0, 8'h61);    send(0, 0, 0, 3'd0, 12'h000, "R9", 0, 1);
    mk(50, 1'b1, 16'h3004, 8'h62); send(0, 1, 0, 3'd0, 12'h000, "R9", 0, 1);
    mk(64, 1'b1, 16'h3004, 8'h63); send(0, 1, 0, 3'd0, 12'h000, "R9", 0, 1);
    // R10: configuration changes after the start byte are ignored
    mk(64, 1'b0, 16'h0, 8'h71);    send(1, 0, 0, 3'd6, 12'h9F0, "R10", 1, 1);
    mk(64, 1'b1, 16'hE111, 8'h72); send(0, 0, 1, 3'd2, 12'h9F0, "R10", 1, 1);
    // R11: back-to-back frames while the input is held
    mk(16, 1'b0, 16'h0, 8'h81);    send(1, 0, 0, 3'd7, 12'hFFF, "R11", 0, 0);
    mk(30, 1'b1, 16'h5555, 8'h82); send(0, 1, 0, 3'd7, 12'hFFF, "R11", 0, 0);
    mk(64, 1'b0, 16'h0, 8'h83);    send(0, 0, 0, 3'd7, 12'hFFF, "R11", 0, 1);

    for (int w = 0; w < 3000 && expq.size() != 0; w++) @(negedge clk);
    check(expq.size() == 0, "R12", "expected bytes never produced", expq.size(), 0);
    summary();
    $finish;
  end

endmodule